// File: doc/BRIEF.md
# Down-Counting Timer with Buffered Reload

This block is a general-purpose timer whose counter only counts down. A programmable prescaler divides the input clock into counter ticks. The counter starts at the active reload value and steps down to zero. On the tick after zero it wraps back to a reload value and signals an underflow.

Software never writes the active period or the active prescale ratio directly. It writes two buffer registers instead. Their contents reach the active registers only when an update event occurs. An update event is either a counter underflow or a software request.

Two control bits change how updates behave:
- An update-off bit blocks the register transfer altogether.
- A quiet-software bit stops software-requested updates from raising the interrupt flag.

A reload-buffering bit decides whether a write to the reload buffer waits for the next update or also takes effect at once. Software reaches the block through a plain register write port and a combinational read port. The block drives a sticky update-interrupt flag.

Top module: `dntimer`

## Requirements
- R1: After reset, every register reads 0 except the reload buffer (address 4) and the active reload (address 7), which both read 0xFFFF. The flag output is 0. Register addresses are: 0 control, 1 event, 2 flag, 3 prescale buffer, 4 reload buffer, 5 counter (read only), 6 active prescale (read only), 7 active reload (read only). Control bits are: bit0 run, bit1 update-off, bit2 quiet-software, bit3 reload-buffered.
- R2: While run is 1, the counter changes once every P+1 clocks, where P is the active prescale ratio.
- R3: On each tick the counter decrements by one. A tick that finds the counter at 0 is an underflow and reloads the counter.
- R4: When update-off is 0, an update event copies the prescale buffer into the active prescale and the reload buffer into the active reload. The counter then restarts from the newly copied reload value in the same cycle.
- R5: When update-off is 1, an underflow or software update leaves both active registers unchanged and does not set the flag. The counter still restarts from the current active reload, and the prescaler count returns to 0.
- R6: When quiet-software is 1, a software update performs the transfer but does not set the flag. An underflow still sets it.
- R7: The flag sets on the clock edge of any update event that is not suppressed, and then stays set. Writing 1 to address 2 bit0 clears it. Writing 0 has no effect. A set in the same cycle wins over a clear.
- R8: When reload-buffered is 0, a write to the reload buffer also lands in the active reload on the same edge. When reload-buffered is 1, the active reload keeps its value until the next update. If a transfer happens in the same cycle as the write, the transfer takes priority.
- R9: Writing 1 to address 2's neighbour, event register bit0 (address 1), requests a software update. It works even while run is 0, clears the prescaler count, and the event register always reads 0.
- R10: While run is 0 and no software update is requested, the counter and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| upd_flag | output | 1 | Sticky update interrupt flag |

## Verification
The bench targets the following corner cases:
- **Underflow at prescale ratio 0.** The counter moves every clock. A prescaler off by one would stretch or shorten each period.
- **Update-off set at an underflow.** A design that still transferred the buffers would pick up the new period. A design that skipped the reload would let the counter wrap to 0xFFFF.
- **Quiet software update.** Done wrongly, it would raise the flag.
- **Flag set and clear in the same cycle.** A design that favours the clear would lose an interrupt.
- **Immediate-mode reload writes.** A design that ignored the buffering bit would leave the old period active until the next update.

Random register traffic with small prescale and reload values drives many underflows into collisions with writes. Every cycle is compared against a bench model of the requirements.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam logic [2:0] ADR_CTRL    = 3'd0;
  localparam logic [2:0] ADR_EVENT   = 3'd1;
  localparam logic [2:0] ADR_FLAG    = 3'd2;
  localparam logic [2:0] ADR_PSCBUF  = 3'd3;
  localparam logic [2:0] ADR_RLDBUF  = 3'd4;
  localparam logic [2:0] ADR_COUNT   = 3'd5;
  localparam logic [2:0] ADR_PSCACT  = 3'd6;
  localparam logic [2:0] ADR_RLDACT  = 3'd7;

  typedef struct packed {
    logic buffered;   // bit3
    logic quiet_sw;   // bit2
    logic upd_off;    // bit1
    logic run;        // bit0
  } ctrl_t;
endpackage

// File: rtl/dntimer_psc.sv
module dntimer_psc #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic [PW-1:0] ratio,
  output logic          tick
);
  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clear) pcnt <= '0;
    else if (run)   pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/dntimer_cnt.sv
module dntimer_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          at_zero
);
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= reload_val;
    else if (tick)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dntimer_regs.sv
module dntimer_regs
  import dntimer_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          underflow,
  output ctrl_t         ctrl,
  output logic [PW-1:0] psc_buf,
  output logic [PW-1:0] psc_act,
  output logic [CW-1:0] rld_buf,
  output logic [CW-1:0] rld_act,
  output logic          flag,
  output logic          sw_upd,
  output logic          evt,
  output logic [CW-1:0] reload_val
);
  logic wr_ctrl, wr_flag, wr_psc, wr_rld, xfer, flag_set;

  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_flag  = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];
  assign wr_psc   = wr_en && (wr_addr == ADR_PSCBUF);
  assign wr_rld   = wr_en && (wr_addr == ADR_RLDBUF);
  assign sw_upd   = wr_en && (wr_addr == ADR_EVENT) && wr_data[0];
  assign evt      = underflow || sw_upd;
  assign xfer     = evt && !ctrl.upd_off;
  assign flag_set = xfer && (underflow || !ctrl.quiet_sw);
  assign reload_val = ctrl.upd_off ? rld_act : rld_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      psc_buf <= '0;
      rld_buf <= '1;
    end else begin
      if (wr_ctrl) ctrl    <= ctrl_t'(wr_data[3:0]);
      if (wr_psc)  psc_buf <= wr_data[PW-1:0];
      if (wr_rld)  rld_buf <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      rld_act <= '1;
    end else if (xfer) begin
      psc_act <= psc_buf;
      rld_act <= rld_buf;
    end else if (wr_rld && !ctrl.buffered) begin
      rld_act <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (wr_flag)  flag <= 1'b0;
  end
endmodule

// File: rtl/dntimer.sv
module dntimer
  import dntimer_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16,
  localparam int DW = (CW > PW) ? CW : PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          upd_flag
);
  ctrl_t         ctrl;
  logic [PW-1:0] psc_buf, psc_act;
  logic [CW-1:0] rld_buf, rld_act, reload_val, cnt;
  logic          tick, at_zero, underflow, sw_upd, evt, flag;

  assign underflow = tick && at_zero;
  assign upd_flag  = flag;

  dntimer_regs #(.CW(CW), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .underflow(underflow), .ctrl(ctrl),
    .psc_buf(psc_buf), .psc_act(psc_act), .rld_buf(rld_buf),
    .rld_act(rld_act), .flag(flag), .sw_upd(sw_upd), .evt(evt),
    .reload_val(reload_val)
  );

  dntimer_psc #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .clear(evt),
    .ratio(psc_act), .tick(tick)
  );

  dntimer_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(evt),
    .reload_val(reload_val), .cnt(cnt), .at_zero(at_zero)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL:   rd_data = DW'(ctrl);
      ADR_EVENT:  rd_data = '0;
      ADR_FLAG:   rd_data = DW'(flag);
      ADR_PSCBUF: rd_data = DW'(psc_buf);
      ADR_RLDBUF: rd_data = DW'(rld_buf);
      ADR_COUNT:  rd_data = DW'(cnt);
      ADR_PSCACT: rd_data = DW'(psc_act);
      default:    rd_data = DW'(rld_act);
    endcase
  end
endmodule

// File: rtl/dntimer_chk.sv
module dntimer_chk #(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          upd_off,
  input logic          quiet,
  input logic          sw_upd,
  input logic          tick,
  input logic          underflow,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld_buf,
  input logic [PW-1:0] psc_act,
  input logic          flag
);
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !sw_upd) |=> cnt == $past(cnt) - 1'b1);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !upd_off) |=> cnt == $past(rld_buf));

  p_keep_psc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> $stable(psc_act));

  p_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_off && !flag) |=> !flag);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd && quiet && !upd_off && !underflow && !flag) |=> !flag);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !upd_off) |=> flag);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_upd) |=> $stable(cnt));
endmodule

bind dntimer dntimer_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl.run), .upd_off(ctrl.upd_off),
  .quiet(ctrl.quiet_sw), .sw_upd(sw_upd), .tick(tick),
  .underflow(underflow), .cnt(cnt), .rld_buf(rld_buf),
  .psc_act(psc_act), .flag(flag)
);

// File: tb/dntimer_bench.sv
module dntimer_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        upd_flag;
  int n_chk = 0, n_fail = 0;
  string req = "R1";
  bit done = 0;

  // model state
  logic [3:0]  m_ctrl = 0;
  logic [15:0] m_pbuf = 0, m_pact = 0, m_pcnt = 0, m_cnt = 0;
  logic [15:0] m_rbuf = 16'hFFFF, m_ract = 16'hFFFF;
  logic        m_flag = 0;

  always #10 clk = ~clk;

  dntimer u_dntimer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .upd_flag(upd_flag));

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {12'b0, m_ctrl};
      3'd1: return 16'h0;
      3'd2: return {15'b0, m_flag};
      3'd3: return m_pbuf;
      3'd4: return m_rbuf;
      3'd5: return m_cnt;
      3'd6: return m_pact;
      default: return m_ract;
    endcase
  endfunction

  task automatic model(input bit we, input logic [2:0] a, input logic [15:0] d);
    bit run = m_ctrl[0], off = m_ctrl[1], quiet = m_ctrl[2], bufd = m_ctrl[3];
    bit tick = run && (m_pcnt == m_pact);
    bit unf = tick && (m_cnt == 0);
    bit sw = we && a == 3'd1 && d[0];
    bit evt = unf || sw;
    bit xfer = evt && !off;
    logic [15:0] n_cnt = m_cnt, n_pcnt = m_pcnt, n_pact = m_pact, n_ract = m_ract;
    logic n_flag = m_flag;
    if (xfer && (unf || !quiet)) n_flag = 1;
    else if (we && a == 3'd2 && d[0]) n_flag = 0;
    if (evt) n_cnt = off ? m_ract : m_rbuf;
    else if (tick) n_cnt = m_cnt - 1;
    if (evt) n_pcnt = 0;
    else if (run) n_pcnt = tick ? 16'd0 : m_pcnt + 1;
    if (xfer) begin n_pact = m_pbuf; n_ract = m_rbuf; end
    else if (we && a == 3'd4 && !bufd) n_ract = d;
    if (we && a == 3'd0) m_ctrl = d[3:0];
    if (we && a == 3'd3) m_pbuf = d;
    if (we && a == 3'd4) m_rbuf = d;
    m_cnt = n_cnt; m_pcnt = n_pcnt; m_pact = n_pact; m_ract = n_ract; m_flag = n_flag;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d, input logic [2:0] rs);
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = rs;
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wr_en = 0;
    check(rd_data, exp_read(rs), $sformatf("read addr %0d", rs));
    check({15'b0, upd_flag}, {15'b0, m_flag}, "flag pin");
  endtask

  task automatic idle(input int n, input logic [2:0] rs);
    for (int i = 0; i < n; i++) step(0, 0, 0, rs);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    req = "R1";
    for (int a = 0; a < 8; a++) step(0, 0, 0, 3'(a));
    // R2/R3 prescale 2, period 5, run buffered
    req = "R2";
    step(1, 3'd3, 16'd2, 3'd5);
    step(1, 3'd4, 16'd5, 3'd5);
    step(1, 3'd1, 16'd1, 3'd5);
    step(1, 3'd0, 16'h9, 3'd5);
    idle(20, 3'd5);
    req = "R3";
    idle(20, 3'd5);
    // R4/R8 buffered write waits for underflow
    req = "R8";
    step(1, 3'd4, 16'd3, 3'd7);
    idle(3, 3'd7);
    req = "R4";
    idle(20, 3'd7);
    // R7 flag clear, write 0 ignored
    req = "R7";
    step(1, 3'd2, 16'd0, 3'd2);
    step(1, 3'd2, 16'd1, 3'd2);
    idle(2, 3'd2);
    // R5 update-off
    req = "R5";
    step(1, 3'd0, 16'hB, 3'd6);
    step(1, 3'd3, 16'd0, 3'd6);
    step(1, 3'd4, 16'd2, 3'd7);
    step(1, 3'd2, 16'd1, 3'd2);
    idle(25, 3'd5);
    step(1, 3'd1, 16'd1, 3'd6);
    idle(2, 3'd7);
    // R6 quiet software update
    req = "R6";
    step(1, 3'd0, 16'hD, 3'd2);
    step(1, 3'd2, 16'd1, 3'd2);
    step(1, 3'd1, 16'd1, 3'd2);
    idle(3, 3'd6);
    idle(15, 3'd2);
    // R8 immediate mode
    req = "R8";
    step(1, 3'd0, 16'h1, 3'd7);
    step(1, 3'd4, 16'd7, 3'd7);
    idle(2, 3'd7);
    // R10 stop holds, R9 software update while stopped
    req = "R10";
    step(1, 3'd0, 16'h0, 3'd5);
    idle(6, 3'd5);
    req = "R9";
    step(1, 3'd1, 16'd1, 3'd5);
    step(0, 0, 0, 3'd1);
    idle(3, 3'd5);
    // random mix
    req = "R3";
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a = 3'($urandom % 8);
      logic [15:0] d = 16'($urandom);
      bit we = ($urandom % 10) < 3;
      if (a == 3'd0) d = {12'b0, d[3:1], ($urandom % 6) != 0};
      else if (a == 3'd3) d = d % 4;
      else if (a == 3'd4) d = d % 12;
      step(we, a, d, 3'($urandom % 8));
    end
    done = 1;
    summary();
  end
endmodule